// File: doc/BRIEF.md
# TDM Serial Frame Receiver

This block receives eight serial time-division streams that share one clock and one active-low frame sync. Each stream carries 32 eight-bit channels per frame, most significant bit first, and every bit cell lasts two clock periods. The 512-cycle frame repeats continuously. A frame counter inside the block produces the bit and channel timing. When the sync input is sampled low, the counter is set back to the start of the frame.

Each stream has its own shift register, which samples the line once per bit cell on the second clock of that cell. After the eighth bit of a channel, the eight received bytes are captured together. They are then written into a 256 x 8 sample store one per cycle, at address {stream, channel}. A later output stage can therefore pick any input slot. The block exports the current channel index, the bit number and a frame-start strobe so that neighbouring logic stays aligned. It also provides a registered read port into the store.

Top module: `tdm_frame_rx`

## Requirements
- R1: While `rst` is high, `chan_idx` reads 0, `bit_idx` reads 7 and `frame_start` reads 1 after the next clock edge.
- R2: With `fsync_n` high, every bit cell lasts two cycles. `bit_idx` counts 7 down to 0 within a channel, `chan_idx` advances every 16 cycles, and the frame wraps to channel 0 after 512 cycles.
- R3: When `fsync_n` is sampled low at any point in the frame, the cycle after that edge shows channel 0, bit 7 and `frame_start` high.
- R4: Each `ser_in` line is sampled at the clock edge that ends the second cycle of a bit cell. What the line carries during the first cycle of the cell has no effect. The first bit received in a channel is the byte's MSB.
- R5: After the eighth bit of channel c, the byte of stream s is written to store address s*32 + c (stream in the upper 3 address bits, channel in the lower 5). The eight streams are written in order 0 to 7, one per cycle, starting the cycle after capture.
- R6: `frame_start` is high exactly in the cycles where the counter is at channel 0, bit 7, first half of the cell.
- R7: While `fsync_n` is held low, the counter stays at frame start, no channel completes and, once the pending burst ends, the store is not written.
- R8: A channel cut short by a realignment is not written. Its store location keeps its earlier byte.
- R9: `rd_data` shows the store contents at `rd_addr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate x2 clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync_n | input | 1 | Active-low frame sync, sampled on each edge |
| ser_in | input | 8 | One serial data line per stream |
| rd_addr | input | 8 | Store read address {stream, channel} |
| rd_data | output | 8 | Registered store read data |
| chan_idx | output | 5 | Current channel number |
| bit_idx | output | 3 | Current bit number, 7 first |
| frame_start | output | 1 | High in the first cycle of a frame |

## Verification
The counter outputs change at the edge that follows the cycle they describe. The bench therefore compares them on the falling edge of every cycle k after the aligning edge, against k/16, 7-(k/2)%8 and k==0. A channel's bytes are captured at the edge that ends cycle 16c+15 and land in the store over the next eight edges. A read returns one edge after its address. To keep these results clear of the write burst, the bench holds sync low for a dozen cycles before reading the store back. It presents each address on one falling edge and compares on the next one. Each bit cell carries the inverted value in its first cycle, so sampling in the wrong half shows up as corrupted bytes.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int unsigned DEF_STREAMS  = 8;
  localparam int unsigned DEF_CHANNELS = 32;
  localparam int unsigned DEF_BITS     = 8;
endpackage

// File: rtl/tdm_rx_timing.sv
module tdm_rx_timing #(
  parameter int unsigned N_CH = tdm_rx_pkg::DEF_CHANNELS,
  parameter int unsigned BITS = tdm_rx_pkg::DEF_BITS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fsync_n,
  output logic [$clog2(N_CH)-1:0] chan,
  output logic [$clog2(BITS)-1:0] bit_pos,
  output logic                    sample_en,
  output logic                    last_bit,
  output logic                    frame_start
);
  localparam int unsigned BW    = $clog2(BITS);
  localparam int unsigned CW    = $clog2(N_CH);
  localparam int unsigned CYC_W = 1 + BW + CW;

  // cycle counter: [0] half of cell, [BW:1] bit in channel, upper bits channel
  logic [CYC_W-1:0] cyc;
  logic             sof_q;

  always_ff @(posedge clk) begin
    if (rst || !fsync_n) begin
      cyc   <= '0;
      sof_q <= 1'b1;
    end else begin
      cyc   <= cyc + 1'b1;
      sof_q <= &cyc;
    end
  end

  assign sample_en   = cyc[0];
  assign last_bit    = cyc[0] & (&cyc[BW:1]);
  assign bit_pos     = cyc[BW:1];
  assign chan        = cyc[CYC_W-1:BW+1];
  assign frame_start = sof_q;
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int unsigned N_STREAMS = tdm_rx_pkg::DEF_STREAMS,
  parameter int unsigned N_CH      = tdm_rx_pkg::DEF_CHANNELS,
  parameter int unsigned BITS      = tdm_rx_pkg::DEF_BITS
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [N_STREAMS-1:0]                      ser_in,
  input  logic                                      sample_en,
  input  logic                                      last_bit,
  input  logic [$clog2(N_CH)-1:0]                   chan,
  output logic                                      wr_en,
  output logic [$clog2(N_STREAMS)+$clog2(N_CH)-1:0] wr_addr,
  output logic [BITS-1:0]                           wr_data
);
  localparam int unsigned SW = $clog2(N_STREAMS);
  localparam int unsigned CW = $clog2(N_CH);

  logic [BITS-1:0] lane_byte [N_STREAMS];
  logic [BITS-1:0] hold      [N_STREAMS];
  logic [CW-1:0]   hold_ch;
  logic [SW-1:0]   wcnt;
  logic            busy;

  // one shifter per stream; the completed byte includes the bit on the line now
  for (genvar g = 0; g < N_STREAMS; g++) begin : g_lane
    logic [BITS-2:0] sh;
    always_ff @(posedge clk) begin
      if (rst)            sh <= '0;
      else if (sample_en) sh <= {sh[BITS-3:0], ser_in[g]};
    end
    assign lane_byte[g] = {sh, ser_in[g]};
  end

  // capture all lanes at once, then drain them to the store one per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      wcnt    <= '0;
      hold_ch <= '0;
      for (int s = 0; s < N_STREAMS; s++) hold[s] <= '0;
    end else if (last_bit) begin
      busy    <= 1'b1;
      wcnt    <= '0;
      hold_ch <= chan;
      for (int s = 0; s < N_STREAMS; s++) hold[s] <= lane_byte[s];
    end else if (busy) begin
      wcnt <= wcnt + 1'b1;
      if (wcnt == SW'(N_STREAMS - 1)) busy <= 1'b0;
    end
  end

  assign wr_en   = busy;
  assign wr_addr = {wcnt, hold_ch};
  assign wr_data = hold[wcnt];
endmodule

// File: rtl/tdm_rx_store.sv
module tdm_rx_store #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = tdm_rx_pkg::DEF_BITS
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx #(
  parameter int unsigned N_STREAMS = tdm_rx_pkg::DEF_STREAMS,
  parameter int unsigned N_CH      = tdm_rx_pkg::DEF_CHANNELS,
  parameter int unsigned BITS      = tdm_rx_pkg::DEF_BITS
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      fsync_n,
  input  logic [N_STREAMS-1:0]                      ser_in,
  input  logic [$clog2(N_STREAMS)+$clog2(N_CH)-1:0] rd_addr,
  output logic [BITS-1:0]                           rd_data,
  output logic [$clog2(N_CH)-1:0]                   chan_idx,
  output logic [$clog2(BITS)-1:0]                   bit_idx,
  output logic                                      frame_start
);
  localparam int unsigned BW = $clog2(BITS);
  localparam int unsigned AW = $clog2(N_STREAMS) + $clog2(N_CH);

  logic          sample_en, last_bit, wr_en;
  logic [BW-1:0] bit_pos;
  logic [AW-1:0] wr_addr;
  logic [BITS-1:0] wr_data;

  tdm_rx_timing #(.N_CH(N_CH), .BITS(BITS)) u_timing (
    .clk(clk), .rst(rst), .fsync_n(fsync_n), .chan(chan_idx), .bit_pos(bit_pos),
    .sample_en(sample_en), .last_bit(last_bit), .frame_start(frame_start)
  );

  tdm_rx_deser #(.N_STREAMS(N_STREAMS), .N_CH(N_CH), .BITS(BITS)) u_deser (
    .clk(clk), .rst(rst), .ser_in(ser_in), .sample_en(sample_en), .last_bit(last_bit),
    .chan(chan_idx), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  tdm_rx_store #(.AW(AW), .DW(BITS)) u_store (
    .clk(clk), .we(wr_en), .wa(wr_addr), .wd(wr_data), .ra(rd_addr), .rd(rd_data)
  );

  // MSB-first numbering on the outside
  assign bit_idx = BW'(BITS - 1) - bit_pos;
endmodule

// File: rtl/tdm_frame_rx_chk.sv
module tdm_frame_rx_chk #(
  parameter int unsigned N_STREAMS = 8,
  parameter int unsigned N_CH      = 32,
  parameter int unsigned BITS      = 8
) (
  input logic                                      clk,
  input logic                                      rst,
  input logic                                      fsync_n,
  input logic [$clog2(N_CH)-1:0]                   chan_idx,
  input logic [$clog2(BITS)-1:0]                   bit_idx,
  input logic                                      frame_start,
  input logic                                      wr_en,
  input logic [$clog2(N_STREAMS)+$clog2(N_CH)-1:0] wr_addr
);
  localparam int unsigned BW = $clog2(BITS);
  localparam int unsigned CW = $clog2(N_CH);
  localparam int unsigned SW = $clog2(N_STREAMS);
  localparam int unsigned AW = SW + CW;
  localparam int unsigned LW = $clog2(N_STREAMS + 2) + 1;

  logic [LW-1:0] low_cnt;
  always_ff @(posedge clk) begin
    if (rst || fsync_n)   low_cnt <= '0;
    else if (~&low_cnt)   low_cnt <= low_cnt + 1'b1;
  end

  p_sync_r3: assert property (@(posedge clk) disable iff (rst)
    !fsync_n |=> (chan_idx == '0 && bit_idx == BW'(BITS - 1) && frame_start));

  p_sof_pos_r6: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (chan_idx == '0 && bit_idx == BW'(BITS - 1)));

  p_burst_first_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> (wr_addr[AW-1:CW] == '0));

  p_burst_step_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |->
      (wr_addr[AW-1:CW] == SW'($past(wr_addr[AW-1:CW]) + 1'b1)
       && wr_addr[CW-1:0] == $past(wr_addr[CW-1:0])));

  p_freeze_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (low_cnt > LW'(N_STREAMS)) |-> !wr_en);
endmodule

bind tdm_frame_rx tdm_frame_rx_chk #(.N_STREAMS(N_STREAMS), .N_CH(N_CH), .BITS(BITS)) u_chk (
  .clk(clk), .rst(rst), .fsync_n(fsync_n), .chan_idx(chan_idx), .bit_idx(bit_idx),
  .frame_start(frame_start), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/tdm_frame_rx_bench.sv
`timescale 1ns/1ps
module tdm_frame_rx_bench;
  localparam int NS = 8;
  localparam int NC = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync_n = 1'b1;
  logic [7:0] ser_in = '0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [4:0] chan_idx;
  logic [2:0] bit_idx;
  logic       frame_start;

  int  errs = 0;
  int  checks = 0;
  bit  done = 1'b0;
  bit [7:0] model [256];
  bit [7:0] fd [NS][NC];

  always #2.5 clk = ~clk;

  tdm_frame_rx u_tdm_frame_rx (
    .clk(clk), .rst(rst), .fsync_n(fsync_n), .ser_in(ser_in), .rd_addr(rd_addr),
    .rd_data(rd_data), .chan_idx(chan_idx), .bit_idx(bit_idx), .frame_start(frame_start)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic gen(input bit corner);
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) fd[s][c] = 8'($urandom());
    if (corner) begin
      fd[0][0] = 8'h80; fd[7][31] = 8'h01; fd[3][5] = 8'hFF; fd[4][19] = 8'h00;
      fd[1][0] = 8'h01; fd[6][31] = 8'hFE;
    end
  endtask

  // align, then run nk cycles; a sync pulse ends the run
  task automatic send(input int nk);
    @(negedge clk) fsync_n = 1'b0;
    @(posedge clk);
    for (int k = 0; k < nk; k++) begin
      @(negedge clk);
      chk(chan_idx == 5'(k / 16), "R2 chan_idx", chan_idx, k / 16);
      chk(bit_idx == 3'(7 - (k / 2) % 8), "R2 R3 bit_idx", bit_idx, 7 - (k / 2) % 8);
      chk(frame_start == (k == 0), "R6 frame_start", frame_start, k == 0);
      for (int s = 0; s < NS; s++) begin
        // first half of each cell carries the inverse to expose wrong-phase sampling (R4)
        ser_in[s] = (k % 2 == 1) ? fd[s][k / 16][7 - (k / 2) % 8]
                                 : ~fd[s][k / 16][7 - (k / 2) % 8];
      end
      fsync_n = (k == nk - 1) ? 1'b0 : 1'b1;
    end
    @(posedge clk);
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < nk / 16; c++) model[s * NC + c] = fd[s][c];
  endtask

  // sync held low: counter frozen (R7), then read the store back (R5, R8, R9)
  task automatic freeze_read(input string tag);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(chan_idx == 0 && bit_idx == 3'd7 && frame_start, "R7 frozen counter",
          {chan_idx, bit_idx, frame_start}, 9'h00F);
    end
    for (int a = 0; a < 256; a++) begin
      @(negedge clk) rd_addr = 8'(a);
      @(negedge clk);
      chk(rd_data == model[a], tag, rd_data, model[a]);
    end
  endtask

  initial begin
    void'($urandom(32'd4093));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(chan_idx == 0 && bit_idx == 3'd7 && frame_start == 1'b1, "R1 reset state",
        {chan_idx, bit_idx, frame_start}, 9'h00F);
    fsync_n = 1'b0;
    rst = 1'b0;

    gen(1'b1);
    send(512);
    freeze_read("R4 R5 R9 store after full frame");

    gen(1'b0);
    send(200);   // realigned mid channel 12: R3, R8
    freeze_read("R8 R5 store after cut frame");

    gen(1'b1);
    send(512);
    freeze_read("R4 R5 R9 store after corner frame");

    gen(1'b0);
    send(512);
    gen(1'b0);
    send(512);   // back to back: last channel drains into the next frame
    freeze_read("R5 R9 store after consecutive frames");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule